// File: doc/BRIEF.md
# Warp Divergence Lane-Mask Stack

This block tracks which lanes of a 32-thread warp are active while the warp runs nested if/else code. Every lane steps through every instruction. The active mask only decides which lanes commit results. When the warp reaches a divergent branch, the control logic pulses `push_i` along with a per-lane predicate vector. The block saves the current mask together with that predicate on an internal stack, and narrows the active set to the lanes whose predicate is true.

At the else path, `comp_i` re-forms the mask from the saved entry. It selects the lanes that were active before the branch and had a false predicate. At reconvergence, `pop_i` restores the mask that was active before the branch.

The `any_active_o` output lets the sequencer skip a path that no lane takes. Overflow and underflow outputs report stack misuse. A command that causes an error is not applied.

Top module: `dvg_mask_stack`

## Requirements
- R1: After reset, `mask_o` is all ones, the stack is empty, and both error outputs are low.
- R2: A push on a stack that is not full saves the current mask and `pred_i` as a new top entry. The mask becomes the old mask AND `pred_i`.
- R3: A complement on a non-empty stack sets the mask to the top entry's saved mask AND NOT the predicate saved with it. The present value of `pred_i` is ignored. The stack is unchanged, so repeating the complement gives the same mask.
- R4: A pop on a non-empty stack sets the mask to the top entry's saved mask and removes that entry.
- R5: A push when DEPTH entries are held raises `overflow_o` for one cycle. The mask and the stack stay unchanged.
- R6: A pop or a complement on an empty stack raises `underflow_o` for one cycle. The mask and the stack stay unchanged.
- R7: When several strobes are high in one cycle, only one acts. Pop beats complement, and complement beats push.
- R8: `any_active_o` is high exactly when at least one bit of `mask_o` is set. It changes in the same cycle as the mask.
- R9: When no strobe is high, the mask and the stack hold, whatever `pred_i` carries.
- R10: The mask and the error outputs change at the first clock edge after the strobe. An error output returns low after one cycle unless another erroneous command follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_i | input | LANES | Per-lane branch predicate |
| push_i | input | 1 | Divergent-branch strobe |
| comp_i | input | 1 | Else-path strobe |
| pop_i | input | 1 | Reconvergence strobe |
| mask_o | output | LANES | Current active-lane mask |
| any_active_o | output | 1 | OR of all mask bits |
| overflow_o | output | 1 | Push attempted on a full stack |
| underflow_o | output | 1 | Pop or complement attempted on an empty stack |

## Verification
A corrupted stack entry or a wrong stack pointer stays hidden until the complement or pop that reads that level. Errors can therefore surface many cycles after the push that caused them, and only at the matching nesting depth. The bench keeps its own queue model and compares the mask, the any-active flag and both error outputs on every clock. Each mismatch is therefore seen on the first cycle it reaches the ports. The bench drives pushes down to full depth with distinct predicates and then unwinds them, so every stack level is read back.

// File: rtl/dvg_pkg.sv
package dvg_pkg;
    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_PUSH = 2'd1,
        CMD_COMP = 2'd2,
        CMD_POP  = 2'd3
    } dvg_cmd_e;
endpackage

// File: rtl/dvg_cmd_decode.sv
module dvg_cmd_decode
    import dvg_pkg::*;
(
    input  logic     push_i,
    input  logic     comp_i,
    input  logic     pop_i,
    input  logic     empty_i,
    input  logic     full_i,
    output dvg_cmd_e cmd_o,
    output logic     ovf_o,
    output logic     unf_o
);
    // pop > complement > push; an erroneous command is dropped
    always_comb begin
        cmd_o = CMD_NONE;
        ovf_o = 1'b0;
        unf_o = 1'b0;
        if (pop_i) begin
            if (empty_i) unf_o = 1'b1;
            else         cmd_o = CMD_POP;
        end else if (comp_i) begin
            if (empty_i) unf_o = 1'b1;
            else         cmd_o = CMD_COMP;
        end else if (push_i) begin
            if (full_i)  ovf_o = 1'b1;
            else         cmd_o = CMD_PUSH;
        end
    end
endmodule

// File: rtl/dvg_stack_mem.sv
module dvg_stack_mem #(
    parameter int LANES = 32,
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [LANES-1:0] wr_mask_i,
    input  logic [LANES-1:0] wr_pred_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [LANES-1:0] rd_mask_o,
    output logic [LANES-1:0] rd_pred_o
);
    logic [LANES-1:0] ent_mask_q [DEPTH];
    logic [LANES-1:0] ent_pred_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        logic sel;
        assign sel = wr_en_i && (wr_idx_i == IDX_W'(g));
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_mask_q[g] <= '0;
                ent_pred_q[g] <= '0;
            end else if (sel) begin
                ent_mask_q[g] <= wr_mask_i;
                ent_pred_q[g] <= wr_pred_i;
            end
        end
    end

    assign rd_mask_o = ent_mask_q[rd_idx_i];
    assign rd_pred_o = ent_pred_q[rd_idx_i];
endmodule

// File: rtl/dvg_mask_calc.sv
module dvg_mask_calc
    import dvg_pkg::*;
#(
    parameter int LANES = 32
) (
    input  dvg_cmd_e         cmd_i,
    input  logic [LANES-1:0] cur_mask_i,
    input  logic [LANES-1:0] pred_i,
    input  logic [LANES-1:0] top_mask_i,
    input  logic [LANES-1:0] top_pred_i,
    output logic [LANES-1:0] next_mask_o
);
    always_comb begin
        unique case (cmd_i)
            CMD_PUSH: next_mask_o = cur_mask_i & pred_i;
            CMD_COMP: next_mask_o = top_mask_i & ~top_pred_i;
            CMD_POP:  next_mask_o = top_mask_i;
            default:  next_mask_o = cur_mask_i;
        endcase
    end
endmodule

// File: rtl/dvg_mask_stack.sv
module dvg_mask_stack
    import dvg_pkg::*;
#(
    parameter int LANES = 32,
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] pred_i,
    input  logic             push_i,
    input  logic             comp_i,
    input  logic             pop_i,
    output logic [LANES-1:0] mask_o,
    output logic             any_active_o,
    output logic             overflow_o,
    output logic             underflow_o
);
    typedef struct packed {
        logic [LANES-1:0] mask;
        logic [CNT_W-1:0] depth;
        logic             ovf;
        logic             unf;
    } state_t;

    state_t s_d, s_q;

    dvg_cmd_e         cmd;
    logic             dec_ovf, dec_unf;
    logic             empty, full;
    logic [CNT_W-1:0] top_ptr;
    logic [LANES-1:0] top_mask, top_pred, nxt_mask;
    logic [CNT_W-1:0] stack_depth;

    assign empty       = (s_q.depth == '0);
    assign full        = (s_q.depth == CNT_W'(DEPTH));
    assign top_ptr     = s_q.depth - CNT_W'(1);
    assign stack_depth = s_q.depth;

    dvg_cmd_decode u_dec (
        .push_i (push_i),
        .comp_i (comp_i),
        .pop_i  (pop_i),
        .empty_i(empty),
        .full_i (full),
        .cmd_o  (cmd),
        .ovf_o  (dec_ovf),
        .unf_o  (dec_unf)
    );

    dvg_stack_mem #(.LANES(LANES), .DEPTH(DEPTH)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (cmd == CMD_PUSH),
        .wr_idx_i (s_q.depth[IDX_W-1:0]),
        .wr_mask_i(s_q.mask),
        .wr_pred_i(pred_i),
        .rd_idx_i (top_ptr[IDX_W-1:0]),
        .rd_mask_o(top_mask),
        .rd_pred_o(top_pred)
    );

    dvg_mask_calc #(.LANES(LANES)) u_calc (
        .cmd_i      (cmd),
        .cur_mask_i (s_q.mask),
        .pred_i     (pred_i),
        .top_mask_i (top_mask),
        .top_pred_i (top_pred),
        .next_mask_o(nxt_mask)
    );

    always_comb begin
        s_d      = s_q;
        s_d.mask = nxt_mask;
        s_d.ovf  = dec_ovf;
        s_d.unf  = dec_unf;
        unique case (cmd)
            CMD_PUSH: s_d.depth = s_q.depth + CNT_W'(1);
            CMD_POP:  s_d.depth = s_q.depth - CNT_W'(1);
            default:  s_d.depth = s_q.depth;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.mask  <= '1;
            s_q.depth <= '0;
            s_q.ovf   <= 1'b0;
            s_q.unf   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mask_o       = s_q.mask;
    assign any_active_o = |s_q.mask;
    assign overflow_o   = s_q.ovf;
    assign underflow_o  = s_q.unf;
endmodule

// File: rtl/dvg_mask_stack_chk.sv
module dvg_mask_stack_chk #(
    parameter int LANES = 32,
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LANES-1:0] pred_i,
    input logic             push_i,
    input logic             comp_i,
    input logic             pop_i,
    input logic [LANES-1:0] mask_o,
    input logic             overflow_o,
    input logic             underflow_o,
    input logic [CNT_W-1:0] depth
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    p_push_and_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !comp_i && !pop_i && depth != FULL)
        |=> (mask_o == ($past(mask_o) & $past(pred_i))));

    p_pop_depth_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && depth != '0) |=> (depth == $past(depth) - CNT_W'(1)));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !comp_i && !pop_i && depth == FULL)
        |=> (overflow_o && $stable(mask_o) && $stable(depth)));

    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((pop_i || comp_i) && depth == '0)
        |=> (underflow_o && $stable(mask_o) && $stable(depth)));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_i && !comp_i && !pop_i)
        |=> ($stable(mask_o) && $stable(depth) && !overflow_o && !underflow_o));

    p_depth_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (depth <= FULL) && !(overflow_o && underflow_o));
endmodule

bind dvg_mask_stack dvg_mask_stack_chk #(
    .LANES(LANES), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pred_i     (pred_i),
    .push_i     (push_i),
    .comp_i     (comp_i),
    .pop_i      (pop_i),
    .mask_o     (mask_o),
    .overflow_o (overflow_o),
    .underflow_o(underflow_o),
    .depth      (stack_depth)
);

// File: tb/dvg_mask_stack_tb.sv
`timescale 1ns/1ps
module dvg_mask_stack_tb;
    localparam int LANES = 32;
    localparam int DEPTH = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LANES-1:0] pred_i = '0;
    logic             push_i = 1'b0, comp_i = 1'b0, pop_i = 1'b0;
    logic [LANES-1:0] mask_o;
    logic             any_active_o, overflow_o, underflow_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    dvg_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .pred_i(pred_i),
        .push_i(push_i), .comp_i(comp_i), .pop_i(pop_i),
        .mask_o(mask_o), .any_active_o(any_active_o),
        .overflow_o(overflow_o), .underflow_o(underflow_o)
    );

    // reference model
    logic [LANES-1:0] m_mask;
    logic [LANES-1:0] q_mask[$];
    logic [LANES-1:0] q_pred[$];
    bit               m_ovf, m_unf;
    string            m_tag;

    function automatic void check(bit ok, string tag, string what,
                                  logic [LANES-1:0] act, logic [LANES-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endfunction

    task automatic compare_all();
        check(mask_o === m_mask, m_tag, "mask", mask_o, m_mask);
        check(any_active_o === (m_mask != '0), "R8", "any_active",
              LANES'(any_active_o), LANES'(m_mask != '0));
        check(overflow_o === m_ovf, m_tag == "" ? "R10" : m_tag, "overflow",
              LANES'(overflow_o), LANES'(m_ovf));
        check(underflow_o === m_unf, m_tag == "" ? "R10" : m_tag, "underflow",
              LANES'(underflow_o), LANES'(m_unf));
    endtask

    function automatic void model_step(bit pu, bit co, bit po, logic [LANES-1:0] pr);
        int n;
        m_ovf = 0;
        m_unf = 0;
        n = q_mask.size();
        if (po) begin
            if (n == 0) begin m_unf = 1; m_tag = "R6"; end
            else begin
                m_mask = q_mask.pop_back();
                void'(q_pred.pop_back());
                m_tag = (co || pu) ? "R7" : "R4";
            end
        end else if (co) begin
            if (n == 0) begin m_unf = 1; m_tag = "R6"; end
            else begin
                m_mask = q_mask[n-1] & ~q_pred[n-1];
                m_tag = pu ? "R7" : "R3";
            end
        end else if (pu) begin
            if (n == DEPTH) begin m_ovf = 1; m_tag = "R5"; end
            else begin
                q_mask.push_back(m_mask);
                q_pred.push_back(pr);
                m_mask = m_mask & pr;
                m_tag = "R2";
            end
        end else begin
            m_tag = "R9";
        end
    endfunction

    // drive one cycle at the falling edge, apply to model after the rising edge,
    // compare at the next falling edge
    task automatic step(bit pu, bit co, bit po, logic [LANES-1:0] pr);
        push_i = pu; comp_i = co; pop_i = po; pred_i = pr;
        @(posedge clk);
        model_step(pu, co, po, pr);
        @(negedge clk);
        compare_all();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stim
        m_mask = '1; m_ovf = 0; m_unf = 0; m_tag = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();                                   // R1 reset state

        // R9: predicate alone has no effect
        step(0, 0, 0, 32'h0F0F_1234);
        // R6: underflow on empty stack, pop and complement
        step(0, 0, 1, '0);
        step(0, 0, 0, '0);                               // R10 flag clears
        step(0, 1, 0, 32'hFFFF_0000);
        // R2: nest to full depth with distinct predicates
        for (int i = 0; i < DEPTH; i++)
            step(1, 0, 0, ~(32'h1 << (i * 3)) & 32'hF7FF_FFFF ^ (32'h1 << i));
        // R5: overflow, mask unchanged
        step(1, 0, 0, '0);
        step(1, 0, 0, 32'h0000_0001);
        // R3: complement twice, current predicate ignored
        step(0, 1, 0, 32'hAAAA_AAAA);
        step(0, 1, 0, 32'h5555_5555);
        // R4: unwind every level
        for (int i = 0; i < DEPTH; i++) begin
            step(0, 1, 0, '0);
            step(0, 0, 1, '0);
        end
        step(0, 0, 1, '0);                               // R6 again
        // R8: zero predicate empties the mask
        step(1, 0, 0, '0);
        step(0, 1, 0, '0);
        step(0, 0, 1, '0);
        // R7: simultaneous strobes
        step(1, 0, 0, 32'h00FF_00FF);
        step(1, 1, 0, 32'h1234_5678);
        step(1, 1, 1, 32'h1234_5678);
        step(0, 1, 1, '0);                               // empty: R6 via pop
        // random nested traffic
        for (int k = 0; k < 4000; k++) begin
            int r;
            bit pu, co, po;
            r  = $urandom_range(0, 99);
            pu = (r < 40) || (r > 95);
            co = (r >= 40 && r < 60) || r == 99;
            po = (r >= 60 && r < 85) || r == 98;
            step(pu, co, po, $urandom());
        end
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule